// File: doc/BRIEF.md
# Control-register handshake master

This block drives the four-phase, level-based handshake of a PHY control-register port. A requester gives it a 16-bit register address, a 16-bit write value, a read/write select and a one-cycle start strobe. The master then runs the port through its phases. An address phase comes first. A write adds a data phase and then a write commit. A read adds a read commit, during which the register value is sampled from the port's data-out bus.

The port has one shared 16-bit input bus, four mutually exclusive strobes and one ack line. Each phase follows the same steps. The bus value is held for a settle window with no strobe. Then the phase strobe is raised and held until ack rises. The strobe is then dropped while the bus is kept unchanged, and the master waits for ack to fall. Each ack wait is limited by a cycle counter. If the counter expires, the access is aborted with an error. The block reports completion with a one-cycle done pulse and holds busy for the whole access.

Top module: `crbus_master`

## Requirements
- R1: After reset, busy, done, err, every strobe and the data-in bus are all 0.
- R2: When idle, start is accepted and busy is 1 on the next cycle until done. A start that arrives while busy is ignored: no second access runs.
- R3: Every phase holds its data-in value for SETTLE_CYCLES (default 2) cycles with no strobe high before raising its strobe. The address phase carries the address.
- R4: A strobe stays high until ack is seen high, then drops with data-in unchanged. The next phase begins only after ack is seen low, so no strobe rises while ack is high.
- R5: A read performs the address phase, then drives data-in to 0 and raises the read strobe. When ack is high, the master samples data-out into rdata_o.
- R6: A write performs the address phase, then a capture-data phase carrying the value, then a write-strobe phase carrying the same value on data-in.
- R7: At most one strobe is high at any time. The strobe order is capture-address, read for a read, and capture-address, capture-data, write for a write.
- R8: Done is a single-cycle pulse in the first idle cycle after the final ack fall. For a normal finish, err is 0.
- R9: If ack does not reach the awaited level within TMO_CYCLES cycles of entering a wait, the master drops all strobes and pulses done with err=1, then returns to idle. The strobe stays high for exactly TMO_CYCLES cycles when ack never rises. The same limit applies to the ack-fall wait.
- R10: The timeout counter restarts at each wait. An access whose total ack waiting exceeds TMO_CYCLES, but whose individual waits are each shorter than it, completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | DW | Register address |
| wdata_i | input | DW | Write value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done |
| rdata_o | output | DW | Last value read |
| phy_din_o | output | DW | Port data-in bus |
| phy_cap_addr_o | output | 1 | Capture-address strobe |
| phy_cap_data_o | output | 1 | Capture-data strobe |
| phy_rd_o | output | 1 | Read strobe |
| phy_wr_o | output | 1 | Write strobe |
| phy_dout_i | input | DW | Port data-out bus |
| phy_ack_i | input | 1 | Port acknowledge |

## Verification
The bench uses a register-file PHY model with an adjustable ack latency, so an address captured by a misordered strobe sequence leaves a visible trace. A write followed by a read then returns the wrong register. It measures the no-strobe hold ahead of every strobe: a design that skipped the settle window would show a hold shorter than two cycles. Two timeout cases are covered, ack never rising and ack stuck high. In each, the bench checks the strobe duration and the error flag, and a counter that never expired would hang the run. A slow-ack access with every wait under the limit exposes a counter that is not restarted per wait.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_CMT} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_STROBE, ST_RELEASE} step_e;
endpackage

// File: rtl/crbus_timer.sv
module crbus_timer #(
  parameter int TMO_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(TMO_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i)             cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
  import crbus_pkg::*;
#(
  parameter int DW            = 16,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  input  logic [DW-1:0] dout_i,
  input  logic          expired_i,
  output step_e         step_o,
  output phase_e        phase_o,
  output logic          wr_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          step_chg_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYCLES - 1);

  step_e         step_q, step_d;
  phase_e        phase_q, phase_d;
  logic [SW-1:0] scnt_q;
  logic          wr_q, done_q, err_q;
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic          fin, fail, grab;

  always_comb begin
    step_d  = step_q;
    phase_d = phase_q;
    fin     = 1'b0;
    fail    = 1'b0;
    grab    = 1'b0;
    unique case (step_q)
      ST_IDLE: if (start_i) begin
        step_d  = ST_SETTLE;
        phase_d = PH_ADDR;
      end
      ST_SETTLE: if (scnt_q == SLAST) step_d = ST_STROBE;
      ST_STROBE: begin
        if (ack_i) begin
          step_d = ST_RELEASE;
          grab   = (phase_q == PH_CMT) && !wr_q;
        end else if (expired_i) begin
          step_d = ST_IDLE;
          fail   = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!ack_i) begin
          if (phase_q == PH_CMT) begin
            step_d = ST_IDLE;
            fin    = 1'b1;
          end else begin
            step_d  = ST_SETTLE;
            phase_d = (phase_q == PH_ADDR && wr_q) ? PH_DATA : PH_CMT;
          end
        end else if (expired_i) begin
          step_d = ST_IDLE;
          fail   = 1'b1;
        end
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      phase_q <= PH_ADDR;
      scnt_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      step_q  <= step_d;
      phase_q <= phase_d;
      if (step_d != step_q)         scnt_q <= '0;
      else if (step_q == ST_SETTLE) scnt_q <= scnt_q + 1'b1;
      if (step_q == ST_IDLE && start_i) begin
        wr_q    <= write_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (grab) rdata_q <= dout_i;
      done_q <= fin | fail;
      err_q  <= fail;
    end
  end

  assign step_o     = step_q;
  assign phase_o    = phase_q;
  assign wr_o       = wr_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign step_chg_o = (step_d != step_q);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/crbus_drive.sv
module crbus_drive
  import crbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  step_e         step_i,
  input  phase_e        phase_i,
  input  logic          wr_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] din_o,
  output logic          cap_addr_o,
  output logic          cap_data_o,
  output logic          rd_o,
  output logic          wr_stb_o
);
  logic on;

  always_comb begin
    on = (step_i == ST_STROBE);
    din_o      = '0;
    cap_addr_o = 1'b0;
    cap_data_o = 1'b0;
    rd_o       = 1'b0;
    wr_stb_o   = 1'b0;
    if (step_i != ST_IDLE) begin
      unique case (phase_i)
        PH_ADDR: begin
          din_o      = addr_i;
          cap_addr_o = on;
        end
        PH_DATA: begin
          din_o      = wdata_i;
          cap_data_o = on;
        end
        default: begin
          din_o    = wr_i ? wdata_i : '0;
          wr_stb_o = on && wr_i;
          rd_o     = on && !wr_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/crbus_master.sv
module crbus_master
  import crbus_pkg::*;
#(
  parameter int DW            = 16,
  parameter int SETTLE_CYCLES = 2,
  parameter int TMO_CYCLES    = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] phy_din_o,
  output logic          phy_cap_addr_o,
  output logic          phy_cap_data_o,
  output logic          phy_rd_o,
  output logic          phy_wr_o,
  input  logic [DW-1:0] phy_dout_i,
  input  logic          phy_ack_i
);
  step_e         step;
  phase_e        phase;
  logic          wr, step_chg, expired;
  logic [DW-1:0] addr, wdata;

  crbus_seq #(.DW(DW), .SETTLE_CYCLES(SETTLE_CYCLES)) seq_i (
    .clk_i, .rst_ni, .start_i, .write_i, .addr_i, .wdata_i,
    .ack_i(phy_ack_i), .dout_i(phy_dout_i), .expired_i(expired),
    .step_o(step), .phase_o(phase), .wr_o(wr), .addr_o(addr), .wdata_o(wdata),
    .step_chg_o(step_chg), .done_o, .err_o, .rdata_o
  );

  crbus_timer #(.TMO_CYCLES(TMO_CYCLES)) timer_i (
    .clk_i, .rst_ni,
    .restart_i(step_chg),
    .run_i(step == ST_STROBE || step == ST_RELEASE),
    .expired_o(expired)
  );

  crbus_drive #(.DW(DW)) drive_i (
    .step_i(step), .phase_i(phase), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .din_o(phy_din_o), .cap_addr_o(phy_cap_addr_o), .cap_data_o(phy_cap_data_o),
    .rd_o(phy_rd_o), .wr_stb_o(phy_wr_o)
  );

  assign busy_o = (step != ST_IDLE);
endmodule

// File: rtl/crbus_master_chk.sv
module crbus_master_chk #(
  parameter int DW            = 16,
  parameter int SETTLE_CYCLES = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] phy_din_o,
  input logic          phy_cap_addr_o,
  input logic          phy_cap_data_o,
  input logic          phy_rd_o,
  input logic          phy_wr_o,
  input logic          phy_ack_i
);
  localparam int HW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [HW-1:0] HSAT = HW'(SETTLE_CYCLES);

  logic          any_stb;
  logic [DW-1:0] din_prev_q;
  logic [HW-1:0] hold_q;

  assign any_stb = phy_cap_addr_o | phy_cap_data_o | phy_rd_o | phy_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_prev_q <= '0;
      hold_q     <= '0;
    end else begin
      din_prev_q <= phy_din_o;
      if (any_stb)                    hold_q <= '0;
      else if (phy_din_o != din_prev_q) hold_q <= HW'(1);
      else if (hold_q != HSAT)         hold_q <= hold_q + 1'b1;
    end
  end

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phy_cap_addr_o, phy_cap_data_o, phy_rd_o, phy_wr_o}));

  // R4
  rise_ack_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_stb) |-> !phy_ack_i);

  // R4
  din_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_stb && $past(any_stb)) |-> $stable(phy_din_o));

  // R4
  drop_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_stb) |-> ($past(phy_ack_i) || done_o));

  // R3
  settle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_stb) |-> (hold_q >= HSAT));

  // R9
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !any_stb));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !any_stb));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind crbus_master crbus_master_chk #(.DW(DW), .SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .phy_din_o(phy_din_o),
  .phy_cap_addr_o(phy_cap_addr_o), .phy_cap_data_o(phy_cap_data_o),
  .phy_rd_o(phy_rd_o), .phy_wr_o(phy_wr_o), .phy_ack_i(phy_ack_i)
);

// File: tb/crbus_master_tb.sv
`timescale 1ns/1ps
module crbus_master_tb_top;
  localparam int DW  = 16;
  localparam int SET = 2;
  localparam int TMO = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, write = 1'b0;
  logic [DW-1:0] addr = '0, wdata = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdata, din, dout;
  logic          capa, capd, rd, wr;
  logic          ack;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  crbus_master #(.DW(DW), .SETTLE_CYCLES(SET), .TMO_CYCLES(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(write),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .phy_din_o(din), .phy_cap_addr_o(capa), .phy_cap_data_o(capd),
    .phy_rd_o(rd), .phy_wr_o(wr), .phy_dout_i(dout), .phy_ack_i(ack)
  );

  // PHY model: register file, ack after lat cycles
  int            lat = 2;
  bit            no_ack = 1'b0, stuck_ack = 1'b0;
  int            lcnt;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] cur_addr, cur_data;

  assign dout = mem[cur_addr[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; lcnt <= 0; cur_addr <= '0; cur_data <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'h5000 + DW'(i);
    end else begin
      if (!ack && (capa | capd | rd | wr) && !no_ack) begin
        if (lcnt >= lat - 1) begin
          ack <= 1'b1; lcnt <= 0;
          if (capa) cur_addr <= din;
          if (capd) cur_data <= din;
          if (wr)   mem[cur_addr[3:0]] <= din;
        end else lcnt <= lcnt + 1;
      end else if (ack && !(capa | capd | rd | wr) && !stuck_ack) begin
        if (lcnt >= lat - 1) begin ack <= 1'b0; lcnt <= 0; end
        else lcnt <= lcnt + 1;
      end else lcnt <= 0;
    end
  end

  // monitor
  int            seq_code [8];
  logic [DW-1:0] seq_din [8];
  int            seq_n, min_hold, hold, stb_cycles;
  logic [3:0]    ps;
  logic [DW-1:0] pdin;

  always @(negedge clk) begin
    logic [3:0] s;
    s = {wr, rd, capd, capa};
    if (rst_n) begin
      if (s != 0 && ps == 0) begin
        if (seq_n < 8) begin
          seq_code[seq_n] = capa ? 1 : capd ? 2 : rd ? 3 : 4;
          seq_din[seq_n]  = din;
        end
        seq_n++;
        if (hold < min_hold) min_hold = hold;
      end
      if (s != 0) stb_cycles++;
      if (s != 0)         hold = 0;
      else if (din == pdin) hold++;
      else                hold = 1;
    end
    ps = s; pdin = din;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    seq_n = 0; min_hold = 999; stb_cycles = 0;
  endtask

  task automatic run_op(input bit w, input logic [DW-1:0] a, input logic [DW-1:0] d,
                        output bit e, output logic [DW-1:0] r);
    int n;
    clear_log();
    @(negedge clk);
    start = 1'b1; write = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    e = err; r = rdata;
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
    chk(din == 0 && {capa, capd, rd, wr} == 0, "R1", "port idle after reset",
        {din, capa, capd, rd, wr}, 0);
  endtask

  task automatic t_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
    bit e; logic [DW-1:0] r;
    run_op(1'b1, a, d, e, r);
    chk(e == 1'b0, "R8", "write err", e, 0);
    chk(seq_n == 3, "R6", "write strobe count", seq_n, 3);
    chk(seq_code[0] == 1 && seq_code[1] == 2 && seq_code[2] == 4, "R7", "write order",
        {seq_code[0][7:0], seq_code[1][7:0], seq_code[2][7:0]}, 32'h010204);
    chk(seq_din[0] == a, "R3", "address on data-in", seq_din[0], a);
    chk(seq_din[1] == d && seq_din[2] == d, "R6", "value at data and commit",
        {seq_din[1], seq_din[2]}, {d, d});
    chk(min_hold == SET, "R3", "settle hold before strobes", min_hold, SET);
  endtask

  task automatic t_read(input logic [DW-1:0] a, input logic [DW-1:0] exp);
    bit e; logic [DW-1:0] r;
    run_op(1'b0, a, 16'hFFFF, e, r);
    chk(e == 1'b0, "R8", "read err", e, 0);
    chk(seq_n == 2 && seq_code[0] == 1 && seq_code[1] == 3, "R7", "read order",
        {seq_n[7:0], seq_code[0][7:0], seq_code[1][7:0]}, 32'h020103);
    chk(seq_din[0] == a && seq_din[1] == 0, "R5", "read data-in values",
        {seq_din[0], seq_din[1]}, {a, 16'h0});
    chk(r == exp, "R5", "read data", r, exp);
    chk(min_hold == SET, "R3", "settle hold in read", min_hold, SET);
  endtask

  task automatic t_busy_ignore();
    int n;
    clear_log();
    @(negedge clk);
    start = 1'b1; write = 1'b1; addr = 16'h0005; wdata = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; write = 1'b0; addr = 16'h0009;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R2", "no second access after ignored start", busy, 0);
    chk(seq_n == 3, "R2", "strobes of one write only", seq_n, 3);
    t_read(16'h0005, 16'h7777);
    t_read(16'h0009, 16'h5009);
  endtask

  task automatic t_timeout_rise();
    bit e; logic [DW-1:0] r;
    no_ack = 1'b1;
    run_op(1'b0, 16'h0004, 16'h0, e, r);
    no_ack = 1'b0;
    chk(e == 1'b1, "R9", "err on missing ack", e, 1);
    chk(stb_cycles == TMO, "R9", "strobe cycles before abort", stb_cycles, TMO);
    chk({capa, capd, rd, wr} == 0, "R9", "strobes dropped", {capa, capd, rd, wr}, 0);
  endtask

  task automatic t_timeout_fall();
    bit e; logic [DW-1:0] r;
    stuck_ack = 1'b1;
    run_op(1'b1, 16'h0006, 16'h1111, e, r);
    chk(e == 1'b1, "R9", "err on stuck ack", e, 1);
    chk(seq_n == 1, "R9", "abort in address release", seq_n, 1);
    stuck_ack = 1'b0;
    repeat (10) @(negedge clk);
    t_read(16'h0006, 16'h5006);
  endtask

  task automatic t_slow_ack();
    lat = 30;
    t_write(16'h000C, 16'hC0DE);
    t_read(16'h000C, 16'hC0DE);
    lat = 2;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();                           // R1
    t_write(16'h0003, 16'hBEEF);         // R3 R6 R7
    t_read(16'h0003, 16'hBEEF);          // R5
    t_read(16'h000B, 16'h500B);          // R5 unwritten register
    t_write(16'h000A, 16'h1234);
    t_read(16'h000A, 16'h1234);
    t_busy_ignore();                     // R2
    t_timeout_rise();                    // R9
    t_timeout_fall();                    // R9
    t_slow_ack();                        // R10
    summary();
    $finish;
  end
endmodule